// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for the indexed addressing family of a 16-bit accumulator-style processor. The instruction decoder supplies an addressing mode, a base register choice (X, Y, stack pointer or program counter), the current register and accumulator values, the raw offset field and, for auto modes, a step code. For plain indexed modes the effective address and the completion strobe appear in the same cycle as the request. For the two indirect modes the block first forms a pointer location, then reads two bytes from data memory through an asynchronous byte read port (most significant byte first), and completes after the second byte.

For the auto step modes the block also produces the new base register value with a one-cycle write enable, so the register file can update X, Y, SP or PC together with the access. The pre forms use the stepped value as the address. The post forms use the original value. All address arithmetic wraps modulo 2^16. One adder serves every mode: the offset unit turns each mode's operand into a single two's-complement term.

Top module: `idx_ea_gen`

## Requirements
- R1: Mode code 0 (constant offset): ea = base + offset sign-extended from the width chosen by `off_wsel` (0: low 5 bits, 1: low 9 bits, 2 or 3: all 16 bits). Offset bits above the chosen width have no effect.
- R2: Mode code 1 (accumulator offset): ea = base + accumulator, with `acc_sel` 0 = A, 1 = B (both zero-extended, never sign-extended) and 2 or 3 = D.
- R3: Mode codes 2 (pre-increment) and 3 (pre-decrement): with step = `step_code` + 1 (1 to 8), ea = base ± step and `base_wdata` carries the same value.
- R4: Mode codes 4 (post-increment) and 5 (post-decrement): ea = the unmodified base and `base_wdata` = base ± step.
- R5: `base_sel` picks the base register: 0 = X, 1 = Y, 2 = SP, 3 = PC. The auto modes apply to every one of them.
- R6: Mode code 6 (indirect, constant): pointer = base + the full 16-bit signed offset, whatever `off_wsel` holds. ea = {byte at pointer, byte at pointer + 1}.
- R7: Mode code 7 (indirect, D): pointer = base + D, followed by the same two-byte fetch as R6.
- R8: For modes 0 to 5, `done` is high in the cycle `start` is accepted. For modes 6 and 7, the high byte is read in the next cycle, and the low byte is read one cycle later together with `done`. `done` stays low in the accept cycle and in the high-byte cycle.
- R9: `base_we` pulses for exactly the accept cycle of modes 2 to 5, together with `done`. It never pulses for modes 0, 1, 6 or 7.
- R10: Every sum wraps modulo 2^16, including the low-byte location: a pointer of 0xFFFF reads its low byte from 0x0000.
- R11: A `start` that arrives while an indirect fetch is in progress is ignored: no extra `done`, no `base_we`, and no memory read in the cycle after the fetch ends.
- R12: During reset and after it, with no request pending, `done`, `base_we` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| start | input | 1 | Request strobe for one address calculation |
| mode | input | 3 | Addressing mode code (see R1 to R7) |
| base_sel | input | 2 | Base register choice: 0 X, 1 Y, 2 SP, 3 PC |
| off_wsel | input | 2 | Constant offset width: 0 = 5 bits, 1 = 9 bits, else 16 bits |
| acc_sel | input | 2 | Accumulator offset: 0 A, 1 B, else D |
| step_code | input | 3 | Auto step magnitude minus one |
| offset | input | 16 | Raw offset field |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| mem_rdata | input | 8 | Byte returned by memory for `mem_addr` in the same cycle |
| mem_rd | output | 1 | Memory read strobe during pointer fetch |
| mem_addr | output | 16 | Memory byte location being read |
| ea | output | 16 | Effective address, valid while `done` is high |
| done | output | 1 | Effective address ready |
| base_we | output | 1 | Base register write enable (auto modes) |
| base_wdata | output | 16 | New base register value |

## Verification
The bench builds the block with its default 16-bit address, 5- and 9-bit short offsets and a 3-bit step code. This is small enough to sweep every 5-bit and 9-bit offset, every step and direction, and every base and accumulator choice, on base values that sit at the signed and unsigned wrap points. Memory is a computed byte function of the location, so every pointer fetch has a known result. This includes a pointer at 0xFFFF, whose low byte wraps to 0x0000. Indirect runs are repeated while `start` is held high with an auto mode during the fetch, which shows that a request arriving mid-fetch is ignored.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [2:0] {
    M_CONST     = 3'd0,
    M_ACC       = 3'd1,
    M_PREINC    = 3'd2,
    M_PREDEC    = 3'd3,
    M_POSTINC   = 3'd4,
    M_POSTDEC   = 3'd5,
    M_IND_CONST = 3'd6,
    M_IND_D     = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_HI   = 2'd1,
    F_LO   = 2'd2
  } fetch_st_e;

  function automatic logic mode_is_auto(input logic [2:0] m);
    return (m == M_PREINC) || (m == M_PREDEC) || (m == M_POSTINC) || (m == M_POSTDEC);
  endfunction

  function automatic logic mode_is_post(input logic [2:0] m);
    return (m == M_POSTINC) || (m == M_POSTDEC);
  endfunction

  function automatic logic mode_is_ind(input logic [2:0] m);
    return (m == M_IND_CONST) || (m == M_IND_D);
  endfunction

endpackage

// File: rtl/idx_base_mux.sv
module idx_base_mux #(
  parameter int AW    = 16,
  parameter int NREG  = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic [SELW-1:0] sel,
  input  logic [AW-1:0]   reg_x,
  input  logic [AW-1:0]   reg_y,
  input  logic [AW-1:0]   reg_sp,
  input  logic [AW-1:0]   reg_pc,
  output logic [AW-1:0]   base
);

  logic [AW-1:0] bank [NREG];

  assign bank[0] = reg_x;
  assign bank[1] = reg_y;
  assign bank[2] = reg_sp;
  assign bank[3] = reg_pc;

  assign base = bank[sel];

endmodule

// File: rtl/idx_offset_unit.sv
module idx_offset_unit
  import idx_ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SHORT_W = 5,
  parameter int MID_W   = 9,
  parameter int STEP_W  = 3,
  localparam int BW     = AW / 2
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        off_wsel,
  input  logic [1:0]        acc_sel,
  input  logic [STEP_W-1:0] step_code,
  input  logic [AW-1:0]     offset,
  input  logic [BW-1:0]     acc_a,
  input  logic [BW-1:0]     acc_b,
  input  logic [AW-1:0]     acc_d,
  output logic [AW-1:0]     term
);

  logic [AW-1:0] off_short;
  logic [AW-1:0] off_mid;
  logic [AW-1:0] off_const;
  logic [AW-1:0] acc_term;
  logic [AW-1:0] step_mag;

  // sign extension of the short offset forms
  assign off_short = {{(AW-SHORT_W){offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};
  assign off_mid   = {{(AW-MID_W){offset[MID_W-1]}}, offset[MID_W-1:0]};
  assign step_mag  = AW'(step_code) + AW'(1);

  always_comb begin
    case (off_wsel)
      2'd0:    off_const = off_short;
      2'd1:    off_const = off_mid;
      default: off_const = offset;
    endcase
  end

  // accumulators are unsigned: zero extension only
  always_comb begin
    case (acc_sel)
      2'd0:    acc_term = {{(AW-BW){1'b0}}, acc_a};
      2'd1:    acc_term = {{(AW-BW){1'b0}}, acc_b};
      default: acc_term = acc_d;
    endcase
  end

  always_comb begin
    case (ea_mode_e'(mode))
      M_CONST:               term = off_const;
      M_ACC:                 term = acc_term;
      M_PREINC, M_POSTINC:   term = step_mag;
      M_PREDEC, M_POSTDEC:   term = AW'(0) - step_mag;
      M_IND_CONST:           term = offset;
      default:               term = acc_d;
    endcase
  end

endmodule

// File: rtl/idx_ptr_fetch.sv
module idx_ptr_fetch
  import idx_ea_pkg::*;
#(
  parameter int AW  = 16,
  localparam int BW = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] ptr_in,
  input  logic [BW-1:0] mem_rdata,
  output logic          idle,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          fetch_done,
  output logic [AW-1:0] fetch_ea
);

  fetch_st_e     st_q, st_d;
  logic [AW-1:0] ptr_q;
  logic [BW-1:0] hi_q;
  logic          ptr_en;
  logic          hi_en;

  always_comb begin
    st_d       = st_q;
    ptr_en     = 1'b0;
    hi_en      = 1'b0;
    mem_rd     = 1'b0;
    mem_addr   = ptr_q;
    fetch_done = 1'b0;
    fetch_ea   = {hi_q, mem_rdata};
    case (st_q)
      F_IDLE: begin
        if (launch) begin
          st_d   = F_HI;
          ptr_en = 1'b1;
        end
      end
      F_HI: begin
        mem_rd = 1'b1;
        hi_en  = 1'b1;
        st_d   = F_LO;
      end
      F_LO: begin
        mem_rd     = 1'b1;
        mem_addr   = ptr_q + AW'(1);
        fetch_done = 1'b1;
        st_d       = F_IDLE;
      end
      default: st_d = F_IDLE;
    endcase
  end

  assign idle = (st_q == F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= F_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (ptr_en) ptr_q <= ptr_in;
  end

  always_ff @(posedge clk) begin
    if (hi_en) hi_q <= mem_rdata;
  end

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SHORT_W = 5,
  parameter int MID_W   = 9,
  parameter int STEP_W  = 3,
  localparam int BW     = AW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [1:0]        base_sel,
  input  logic [1:0]        off_wsel,
  input  logic [1:0]        acc_sel,
  input  logic [STEP_W-1:0] step_code,
  input  logic [AW-1:0]     offset,
  input  logic [AW-1:0]     reg_x,
  input  logic [AW-1:0]     reg_y,
  input  logic [AW-1:0]     reg_sp,
  input  logic [AW-1:0]     reg_pc,
  input  logic [BW-1:0]     acc_a,
  input  logic [BW-1:0]     acc_b,
  input  logic [AW-1:0]     acc_d,
  input  logic [BW-1:0]     mem_rdata,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     ea,
  output logic              done,
  output logic              base_we,
  output logic [AW-1:0]     base_wdata
);

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic [AW-1:0] base;
  logic [AW-1:0] term;
  logic [AW-1:0] sum;
  logic          idle;
  logic          accept;
  logic          launch;
  logic          fetch_done;
  logic [AW-1:0] fetch_ea;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  idx_base_mux #(.AW(AW), .NREG(4)) u_base (
    .sel    (base_sel),
    .reg_x  (reg_x),
    .reg_y  (reg_y),
    .reg_sp (reg_sp),
    .reg_pc (reg_pc),
    .base   (base)
  );

  idx_offset_unit #(
    .AW(AW), .SHORT_W(SHORT_W), .MID_W(MID_W), .STEP_W(STEP_W)
  ) u_off (
    .mode      (mode),
    .off_wsel  (off_wsel),
    .acc_sel   (acc_sel),
    .step_code (step_code),
    .offset    (offset),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .acc_d     (acc_d),
    .term      (term)
  );

  // single shared adder, wraps modulo 2^AW
  assign sum    = base + term;
  assign accept = start && idle;
  assign launch = accept && mode_is_ind(mode);

  idx_ptr_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .launch     (launch),
    .ptr_in     (sum),
    .mem_rdata  (mem_rdata),
    .idle       (idle),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .fetch_done (fetch_done),
    .fetch_ea   (fetch_ea)
  );

  always_comb begin
    if (fetch_done)             ea = fetch_ea;
    else if (mode_is_post(mode)) ea = base;
    else                        ea = sum;
  end

  assign done       = fetch_done || (accept && !mode_is_ind(mode));
  assign base_we    = accept && mode_is_auto(mode);
  assign base_wdata = sum;

endmodule

// File: rtl/idx_ea_gen_chk.sv
module idx_ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    mode,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          base_we
);

  // R8
  direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_rd && mode < 3'd6) |-> done);

  // R8
  ind_first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_rd && mode >= 3'd6) |=> (mem_rd && !done));

  // R10
  low_byte_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !done) |=> (mem_rd && done && mem_addr == $past(mem_addr) + AW'(1)));

  // R11
  fetch_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && done) |=> !mem_rd);

  // R9
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (done && !mem_rd && mode >= 3'd2 && mode <= 3'd5));

  // R12
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !mem_rd) |-> (!done && !base_we));

endmodule

bind idx_ea_gen idx_ea_gen_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .mode     (mode),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .done     (done),
  .base_we  (base_we)
);

// File: tb/idx_ea_gen_tb.sv
module idx_ea_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode;
  logic [1:0]  base_sel;
  logic [1:0]  off_wsel;
  logic [1:0]  acc_sel;
  logic [2:0]  step_code;
  logic [15:0] offset;
  logic [15:0] reg_x, reg_y, reg_sp, reg_pc;
  logic [7:0]  acc_a, acc_b;
  logic [15:0] acc_d;
  logic [7:0]  mem_rdata;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] ea;
  logic        done;
  logic        base_we;
  logic [15:0] base_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  idx_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .base_sel(base_sel), .off_wsel(off_wsel), .acc_sel(acc_sel),
    .step_code(step_code), .offset(offset),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .ea(ea), .done(done), .base_we(base_we), .base_wdata(base_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // computed byte memory
  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[15:8] * 8'd7) + (a[7:0] ^ 8'h5C);
  endfunction
  assign mem_rdata = memf(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] basev(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'h1234;
      default: return 16'hABCD;
    endcase
  endfunction

  task automatic set_regs(input logic [15:0] bv);
    reg_x  = bv;
    reg_y  = bv ^ 16'h0F0F;
    reg_sp = bv + 16'h0100;
    reg_pc = bv - 16'h0003;
  endtask

  function automatic logic [15:0] pick(input logic [1:0] s);
    case (s)
      2'd0: return reg_x;
      2'd1: return reg_y;
      2'd2: return reg_sp;
      default: return reg_pc;
    endcase
  endfunction

  // one direct request; expected values from the requirements
  task automatic run_direct(input logic [2:0] m, input logic [1:0] s, input logic [1:0] ow,
                            input logic [1:0] as, input logic [2:0] st, input logic [15:0] off);
    logic [15:0] b, t, e, wd;
    bit auto_m;
    string tag;
    @(negedge clk);
    start = 1'b1; mode = m; base_sel = s; off_wsel = ow; acc_sel = as;
    step_code = st; offset = off;
    b = pick(s);
    auto_m = (m >= 3'd2 && m <= 3'd5);
    case (m)
      3'd0: begin
        tag = "R1/R5/R10";
        if (ow == 2'd0)      t = {{11{off[4]}}, off[4:0]};
        else if (ow == 2'd1) t = {{7{off[8]}}, off[8:0]};
        else                 t = off;
        e = b + t; wd = e;
      end
      3'd1: begin
        tag = "R2/R5/R10";
        if (as == 2'd0)      t = {8'h00, acc_a};
        else if (as == 2'd1) t = {8'h00, acc_b};
        else                 t = acc_d;
        e = b + t; wd = e;
      end
      3'd2: begin tag = "R3/R5"; wd = b + 16'(st) + 16'd1; e = wd; end
      3'd3: begin tag = "R3/R5"; wd = b - 16'(st) - 16'd1; e = wd; end
      3'd4: begin tag = "R4/R5"; wd = b + 16'(st) + 16'd1; e = b; end
      default: begin tag = "R4/R5"; wd = b - 16'(st) - 16'd1; e = b; end
    endcase
    #5;
    chk(done === 1'b1, {tag, " R8 done"}, 16'(done), 16'd1);
    chk(ea === e, {tag, " ea"}, ea, e);
    chk(base_we === auto_m, {tag, " R9 we"}, 16'(base_we), 16'(auto_m));
    if (auto_m) chk(base_wdata === wd, {tag, " wdata"}, base_wdata, wd);
    chk(mem_rd === 1'b0, {tag, " R8 no read"}, 16'(mem_rd), 16'd0);
  endtask

  // one indirect request; optionally hold start with an auto mode during the fetch
  task automatic run_ind(input logic [2:0] m, input logic [1:0] s, input logic [15:0] off,
                         input logic [1:0] ow, input bit hold);
    logic [15:0] ptr, p1, e;
    string tag;
    tag = (m == 3'd6) ? "R6" : "R7";
    @(negedge clk);
    start = 1'b1; mode = m; base_sel = s; offset = off; off_wsel = ow;
    ptr = pick(s) + ((m == 3'd6) ? off : acc_d);
    p1  = ptr + 16'd1;
    e   = {memf(ptr), memf(p1)};
    #5;
    chk(done === 1'b0, {tag, " R8 no early done"}, 16'(done), 16'd0);
    chk(mem_rd === 1'b0, {tag, " R8 no read yet"}, 16'(mem_rd), 16'd0);
    chk(base_we === 1'b0, {tag, " R9 no we"}, 16'(base_we), 16'd0);
    @(negedge clk);
    start = hold; mode = 3'd2; step_code = 3'd5;
    #5;
    chk(mem_rd === 1'b1 && mem_addr === ptr, {tag, " R8 hi addr"}, mem_addr, ptr);
    chk(done === 1'b0, {tag, " R8/R11 no done in hi"}, 16'(done), 16'd0);
    chk(base_we === 1'b0, {tag, " R11 no we in hi"}, 16'(base_we), 16'd0);
    @(negedge clk);
    #5;
    chk(mem_rd === 1'b1 && mem_addr === p1, {tag, " R10 lo addr"}, mem_addr, p1);
    chk(done === 1'b1, {tag, " R8 done"}, 16'(done), 16'd1);
    chk(ea === e, {tag, " ea"}, ea, e);
    chk(base_we === 1'b0, {tag, " R9/R11 no we in lo"}, 16'(base_we), 16'd0);
    @(negedge clk);
    start = 1'b0;
    #5;
    chk(mem_rd === 1'b0 && done === 1'b0, {tag, " R11 fetch over"}, 16'({mem_rd, done}), 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 3'd0; base_sel = 2'd0; off_wsel = 2'd0;
    acc_sel = 2'd0; step_code = 3'd0; offset = 16'h0000;
    acc_a = 8'h00; acc_b = 8'h00; acc_d = 16'h0000;
    set_regs(16'h0000);
    repeat (3) @(negedge clk);
    #5;
    chk(done === 1'b0 && base_we === 1'b0 && mem_rd === 1'b0, "R12 in reset",
        16'({done, base_we, mem_rd}), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    chk(done === 1'b0 && base_we === 1'b0 && mem_rd === 1'b0, "R12 after reset",
        16'({done, base_we, mem_rd}), 16'd0);

    // R1: every 5-bit and 9-bit offset, sampled 16-bit offsets, junk above width
    for (int k = 0; k < 6; k++) begin
      set_regs(basev(k));
      for (int s = 0; s < 4; s++) begin
        for (int o = 0; o < 32; o++)  run_direct(3'd0, 2'(s), 2'd0, 2'd0, 3'd0, 16'hA5A0 | 16'(o));
        for (int o = 0; o < 512; o++) run_direct(3'd0, 2'(s), 2'd1, 2'd0, 3'd0, 16'hB400 | 16'(o));
        for (int o = 0; o < 64; o++)  run_direct(3'd0, 2'(s), 2'(2 + (o & 1)), 2'd0, 3'd0, 16'(o) * 16'h0A3B);
      end
    end

    // R2: accumulator offsets, high-bit values show zero extension
    for (int k = 0; k < 6; k++) begin
      set_regs(basev(k));
      for (int v = 0; v < 8; v++) begin
        acc_a = 8'(8'h80 + v * 17); acc_b = 8'(8'hFF - v * 9); acc_d = 16'(16'h8000 + v * 16'h2345);
        for (int s = 0; s < 4; s++)
          for (int a = 0; a < 4; a++) run_direct(3'd1, 2'(s), 2'd0, 2'(a), 3'd0, 16'hFFFF);
      end
    end

    // R3/R4: every step, direction, timing and base register
    for (int k = 0; k < 6; k++) begin
      set_regs(basev(k));
      for (int m = 2; m < 6; m++)
        for (int s = 0; s < 4; s++)
          for (int st = 0; st < 8; st++) run_direct(3'(m), 2'(s), 2'd0, 2'd0, 3'(st), 16'h1111);
    end
    @(negedge clk);
    start = 1'b0;

    // R6/R7: indirect, width select ignored, wrap at 0xFFFF
    for (int k = 0; k < 6; k++) begin
      set_regs(basev(k));
      acc_d = 16'(16'h00F0 + k * 16'h3001);
      for (int s = 0; s < 4; s++) begin
        run_ind(3'd6, 2'(s), 16'hFF85, 2'd0, 1'b0);
        run_ind(3'd6, 2'(s), 16'h0123, 2'd1, 1'b1);
        run_ind(3'd7, 2'(s), 16'h0000, 2'd0, 1'(s & 1));
      end
    end
    set_regs(16'hFFFF);
    run_ind(3'd6, 2'd0, 16'h0000, 2'd2, 1'b1);
    acc_d = 16'h0000;
    run_ind(3'd7, 2'd0, 16'h0000, 2'd0, 1'b0);

    // R12: idle again, nothing pending
    @(negedge clk);
    start = 1'b0;
    #5;
    chk(done === 1'b0 && base_we === 1'b0 && mem_rd === 1'b0, "R12 idle end",
        16'({done, base_we, mem_rd}), 16'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule